// File: doc/BRIEF.md
# Four-Channel Match-Compare Operating-System Timer

The block is a memory-mapped system timer. A 32-bit counter advances by one on every clock and wraps modulo 2^32. Four compare channels each hold a 32-bit target. On every cycle, each channel tests its target against the counter for equality. A hit latches a sticky per-channel event flag. Software acknowledges a flag by writing a one to its bit. Each channel has an enable bit, and only enabled flags drive a shared level interrupt.

Software schedules an event by reading the counter, adding a delay, and writing the sum to a compare channel. Because the comparison is made against the wrapped count, the delay holds across the 2^32 boundary. Channel 3 can also act as a watchdog. Once the watchdog arm bit is set, a channel-3 hit raises a reset request. Neither the arm bit nor the request can be undone except by reset.

Top module: `ostmr_top`

## Requirements
- R1: Word registers sit at these byte offsets: compare targets for channels 0..3 at 0x00/0x04/0x08/0x0C, counter at 0x10, event flags at 0x14 (bits 3:0), watchdog arm at 0x18 (bit 0), and enables at 0x1C (bits 3:0). Compare and enable registers read back what was written, and unused bits read 0. Accesses whose address bits 1:0 are not 0 are ignored and read 0.
- R2: Without a counter write, the counter grows by exactly one per clock and wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter makes the written value visible in the next cycle, and counting resumes from it.
- R4: When the counter equals channel n's target, flag bit n is set at the following clock edge. This also holds for targets that lie beyond the wrap point.
- R5: A set flag stays set whatever the enable state. Writing 1 to a flag bit clears it, and writing 0 to it has no effect.
- R6: If a hit and a clearing write meet on the same flag bit in the same cycle, the bit ends up set.
- R7: `irqOut` is high exactly while some flag bit and its enable bit are both 1. It falls as soon as the flag is cleared or the enable is cleared.
- R8: Changing one channel's enable bit leaves the counter, all flags and the other channels' contribution to `irqOut` unchanged.
- R9: Writing 1 to watchdog-arm bit 0 sets it. Writing 0 leaves it set, and only reset clears it.
- R10: While the watchdog is armed, a channel-3 hit raises `resetReq` at the next edge, and `resetReq` stays high until reset.
- R11: Reset (`rstN` low) clears the counter, all targets, flags, enables and the watchdog arm bit, and holds `irqOut` and `resetReq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| irqOut | output | 1 | Level interrupt |
| resetReq | output | 1 | Watchdog reset request, sticky |

## Verification
The bench places a compare target beyond the counter's wrap point. A design that compares with a magnitude test or a saturating counter would flag the event too early or never flag it. It times the flag to the exact edge after equality, which exposes a design that is off by one cycle. It lands a clearing write on the very cycle a hit occurs, so a design that lets the clear win would drop the event. It also tries to disarm the watchdog with a zero write and toggles one enable while another channel is pending. These catch an arm bit that can be cleared and enables that leak between channels.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int NUM_CH   = 4;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int IDX_W    = ADDR_W - 2;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int WD_CH    = NUM_CH - 1;
  localparam logic [IDX_W-1:0] IDX_CNT  = IDX_W'(NUM_CH);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(NUM_CH + 1);
  localparam logic [IDX_W-1:0] IDX_WD   = IDX_W'(NUM_CH + 2);
  localparam logic [IDX_W-1:0] IDX_EN   = IDX_W'(NUM_CH + 3);

  typedef struct packed {
    logic [NUM_CH-1:0] cmpWr;
    logic              cntWr;
    logic              statWr;
    logic              wdWr;
    logic              enWr;
    logic              rdValid;
    logic [IDX_W-1:0]  rdIdx;
  } strobe_t;
endpackage

// File: rtl/ostmr_ctrl.sv
module ostmr_ctrl
  import ostmr_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic             aligned;
  logic             wrEn;
  logic [IDX_W-1:0] wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busSel && busWrite && aligned;

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      strb.cmpWr[i] = wrEn && (wordIdx == IDX_W'(i));
    end
    strb.cntWr   = wrEn && (wordIdx == IDX_CNT);
    strb.statWr  = wrEn && (wordIdx == IDX_STAT);
    strb.wdWr    = wrEn && (wordIdx == IDX_WD);
    strb.enWr    = wrEn && (wordIdx == IDX_EN);
    strb.rdValid = busSel && !busWrite && aligned;
    strb.rdIdx   = wordIdx;
  end
endmodule

// File: rtl/ostmr_datapath.sv
module ostmr_datapath
  import ostmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] count,
  output logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] enable,
  output logic              wdEn,
  output logic              irq,
  output logic              rstReq
);
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] cmpQ [NUM_CH];
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] enableQ;
  logic [NUM_CH-1:0] clrMask;
  logic              wdEnQ;
  logic              rstReqQ;

  always_ff @(posedge clk) begin
    if (!rstN)           countQ <= '0;
    else if (strb.cntWr) countQ <= wdata;
    else                 countQ <= countQ + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk) begin
      if (!rstN)              cmpQ[g] <= '0;
      else if (strb.cmpWr[g]) cmpQ[g] <= wdata;
    end
    assign hit[g] = (countQ == cmpQ[g]);
  end

  // a hit in the same cycle as a clear keeps the flag set
  assign clrMask = strb.statWr ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          enableQ <= '0;
    else if (strb.enWr) enableQ <= wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdEnQ   <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      if (strb.wdWr && wdata[0])  wdEnQ   <= 1'b1;
      if (wdEnQ && hit[WD_CH])    rstReqQ <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.rdValid) begin
      if (strb.rdIdx < IDX_W'(NUM_CH)) rdata = cmpQ[strb.rdIdx[CH_W-1:0]];
      else if (strb.rdIdx == IDX_CNT)  rdata = countQ;
      else if (strb.rdIdx == IDX_STAT) rdata[NUM_CH-1:0] = statusQ;
      else if (strb.rdIdx == IDX_WD)   rdata[0] = wdEnQ;
      else if (strb.rdIdx == IDX_EN)   rdata[NUM_CH-1:0] = enableQ;
    end
  end

  assign count  = countQ;
  assign status = statusQ;
  assign enable = enableQ;
  assign wdEn   = wdEnQ;
  assign irq    = |(statusQ & enableQ);
  assign rstReq = rstReqQ;
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
  import ostmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              resetReq
);
  strobe_t           strbW;
  logic [DATA_W-1:0] countW;
  logic [NUM_CH-1:0] hitW;
  logic [NUM_CH-1:0] statusW;
  logic [NUM_CH-1:0] enableW;
  logic              wdEnW;

  ostmr_ctrl uCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strb    (strbW)
  );

  ostmr_datapath uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strbW),
    .wdata (busWdata),
    .rdata (busRdata),
    .count (countW),
    .hit   (hitW),
    .status(statusW),
    .enable(enableW),
    .wdEn  (wdEnW),
    .irq   (irqOut),
    .rstReq(resetReq)
  );
endmodule

// File: rtl/ostmr_checker.sv
module ostmr_checker
  import ostmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] count,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] enable,
  input logic              wdEn,
  input logic              irqOut,
  input logic              resetReq
);
  localparam logic [ADDR_W-1:0] ADDR_CNT  = {IDX_CNT, 2'b00};
  localparam logic [ADDR_W-1:0] ADDR_STAT = {IDX_STAT, 2'b00};

  logic cntWrite;
  logic statWrite;
  assign cntWrite  = busSel && busWrite && (busAddr == ADDR_CNT);
  assign statWrite = busSel && busWrite && (busAddr == ADDR_STAT);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> count == $past(count) + 1'b1);

  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> count == $past(busWdata));

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      hit[g] |=> status[g]);
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
      (status[g] && !(statWrite && busWdata[g])) |=> status[g]);
  end

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable == '0 || status == '0) |-> !irqOut);

  assert_wd_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdEn |=> wdEn);

  assert_wd_fire_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wdEn && hit[WD_CH]) |=> resetReq);

  assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);
endmodule

bind ostmr_top ostmr_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .count   (countW),
  .hit     (hitW),
  .status  (statusW),
  .enable  (enableW),
  .wdEn    (wdEnW),
  .irqOut  (irqOut),
  .resetReq(resetReq)
);

// File: tb/ostmr_top_test.sv
module ostmr_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        resetReq;

  int checks = 0;
  int failures = 0;

  localparam logic [4:0] A_CMP0 = 5'h00, A_CMP1 = 5'h04, A_CMP2 = 5'h08,
                         A_CMP3 = 5'h0C, A_CNT = 5'h10, A_STAT = 5'h14,
                         A_WD = 5'h18, A_EN = 5'h1C;

  // {address, write data}; readback = data, masked to 4 bits for enables
  localparam int NVEC = 7;
  localparam logic [36:0] VEC [NVEC] = '{
    {5'h00, 32'hA5A5_0001}, {5'h04, 32'h5A5A_0002}, {5'h08, 32'hDEAD_0003},
    {5'h0C, 32'hC0DE_0004}, {5'h1C, 32'hFFFF_FFF5}, {5'h1C, 32'h0000_000A},
    {5'h1C, 32'h0000_0000}
  };

  ostmr_top uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .resetReq(resetReq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL timeout actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c0;
    // R11: reset state
    waitEdges(3);
    rd(A_CNT, v);  check("R11 counter", v, 0);
    rd(A_STAT, v); check("R11 flags", v, 0);
    rd(A_EN, v);   check("R11 enables", v, 0);
    rd(A_WD, v);   check("R11 wd arm", v, 0);
    check("R11 irq", {31'b0, irqOut}, 0);
    check("R11 resetReq", {31'b0, resetReq}, 0);
    rstN = 1'b1;
    waitEdges(1);

    // R1: register table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      a = VEC[i][36:32];
      d = VEC[i][31:0];
      wr(a, d);
      rd(a, v);
      check("R1 readback", v, (a == A_EN) ? (d & 32'hF) : d);
    end
    wr(5'h05, 32'h1234_5678);
    rd(A_CMP1, v); check("R1 misaligned write ignored", v, 32'h5A5A_0002);
    rd(5'h11, v);  check("R1 misaligned read", v, 0);
    wr(A_STAT, 32'hF);

    // R3 / R2: load and count
    wr(A_CNT, 32'd100);
    rd(A_CNT, v); check("R3 load visible", v, 100);
    waitEdges(5);
    rd(A_CNT, v); check("R2 step", v, 105);

    // R4 / R5 / R7: match with enable off, then on
    wr(A_CMP0, 32'd1010);
    wr(A_CNT, 32'd1000);
    waitEdges(10);
    rd(A_STAT, v); check("R4 not before equality edge", v & 1, 0);
    waitEdges(1);
    rd(A_STAT, v); check("R4 flag on edge after equality", v & 1, 1);
    check("R7 masked by enable", {31'b0, irqOut}, 0);
    wr(A_EN, 32'h1);
    check("R7 irq raised", {31'b0, irqOut}, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R5 zero write no effect", v & 1, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R5 w1c", v & 1, 0);
    check("R7 irq drops", {31'b0, irqOut}, 0);

    // R4 / R2: wrap
    wr(A_CMP1, 32'd3);
    wr(A_CNT, 32'hFFFF_FFFE);
    waitEdges(5);
    rd(A_CNT, v);  check("R2 wrap", v, 3);
    rd(A_STAT, v); check("R4 wrap early", v & 2, 0);
    waitEdges(1);
    rd(A_STAT, v); check("R4 wrap hit", v & 2, 2);

    // R8: enable independence
    wr(A_EN, 32'h3);
    check("R8 irq from ch1", {31'b0, irqOut}, 1);
    rd(A_CNT, c0);
    wr(A_EN, 32'h2);
    rd(A_CNT, v);  check("R8 counter unaffected", v, c0 + 1);
    rd(A_STAT, v); check("R8 flag kept", v & 2, 2);
    wr(A_EN, 32'h1);
    check("R7 enable clear drops irq", {31'b0, irqOut}, 0);
    rd(A_STAT, v); check("R5 flag held while disabled", v & 2, 2);

    // R6: set beats clear
    wr(A_STAT, 32'hF);
    wr(A_CMP2, 32'd2006);
    wr(A_CNT, 32'd2000);
    waitEdges(6);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v); check("R6 set wins", v & 4, 4);

    // R9 / R10: watchdog
    wr(A_WD, 32'h1);
    rd(A_WD, v); check("R9 arm", v, 1);
    wr(A_WD, 32'h0);
    rd(A_WD, v); check("R9 stays armed", v, 1);
    check("R10 idle", {31'b0, resetReq}, 0);
    wr(A_CMP3, 32'd3004);
    wr(A_CNT, 32'd3000);
    waitEdges(4);
    check("R10 not yet", {31'b0, resetReq}, 0);
    waitEdges(1);
    check("R10 fires", {31'b0, resetReq}, 1);
    waitEdges(3);
    check("R10 held", {31'b0, resetReq}, 1);

    // R11: reset clears sticky state
    rstN = 1'b0;
    waitEdges(1);
    check("R11 resetReq cleared", {31'b0, resetReq}, 0);
    rd(A_WD, v); check("R11 arm cleared", v, 0);
    rstN = 1'b1;
    finishRun();
  end
endmodule